// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces a periodic frame-synchronization level from a sample-clock enable tick. The tick is a one-cycle strobe in the system clock domain. It stands in for a divided sample clock. Two programmable fields set the pulse:

- a width field, which sets how many ticks the output stays high at the start of each frame;
- a period field, which sets how many ticks each frame lasts.

Both countdowns start together at each frame start and run on the same ticks.

Generation runs only while two control inputs are both set: a generator enable and a periodic-mode select. Dropping either one returns the output to low and clears the frame position. The fields are captured only when a frame starts, so software may rewrite them at any time without disturbing the frame in progress.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset (`rst_n` low) `fs_out` is 0.
- R2: While `gen_en` and `per_mode` are not both 1, `fs_out` is 0 from the next clock edge on, whether or not a tick is present, and the frame position is cleared.
- R3: With both control bits at 1, the first tick after the generator was idle starts a frame, and `fs_out` is 1 after that clock edge.
- R4: Counting the start tick as tick 0 of a frame, `fs_out` stays 1 through tick W (where W is the captured `width_fld`) and goes to 0 on tick W+1, provided the frame has not ended before then.
- R5: A frame lasts P+1 ticks (P is the captured `period_fld`). Tick P+1 starts a new frame, sets `fs_out` to 1 and captures both fields again.
- R6: When W >= P the output stays 1 for the whole frame. If the width ends on the same tick as the period, the frame restart wins and `fs_out` stays 1.
- R7: A change of `width_fld` or `period_fld` inside a frame has no effect until the next frame start.
- R8: While enabled, `fs_out` changes only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_en | input | 1 | Generator enable |
| per_mode | input | 1 | Periodic frame-sync mode select |
| width_fld | input | 8 | Pulse width minus one, in ticks |
| period_fld | input | 12 | Frame period minus one, in ticks |
| tick | input | 1 | Sample-clock enable strobe |
| fs_out | output | 1 | Frame-sync level |

## Verification
The width end and the frame restart can fall on the same tick. When they collide, the restart must take priority and keep the output high.

The bench provokes this collision in two ways. Directed runs use W equal to P, W greater than P, and both fields at 0. Random runs draw small fields so that collisions occur often.

Every cycle is judged against a bench model that tracks the tick position inside the frame. The expected output is high exactly while that position is at most W.

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
  parameter int WIDTH_W  = 8,
  parameter int PERIOD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_en,
  input  logic                per_mode,
  input  logic [WIDTH_W-1:0]  width_fld,
  input  logic [PERIOD_W-1:0] period_fld,
  input  logic                tick,
  output logic                fs_out
);

  logic                run;
  logic                fs_q;
  logic [WIDTH_W-1:0]  wcnt;
  logic [PERIOD_W-1:0] pcnt;

  wire active    = gen_en & per_mode;
  wire frame_beg = tick & (~run | (pcnt == '0));
  wire width_end = tick & run & (wcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      fs_q <= 1'b0;
      wcnt <= '0;
      pcnt <= '0;
    end else if (!active) begin
      run  <= 1'b0;
      fs_q <= 1'b0;
      wcnt <= '0;
      pcnt <= '0;
    end else if (frame_beg) begin
      run  <= 1'b1;
      fs_q <= 1'b1;
      wcnt <= width_fld;
      pcnt <= period_fld;
    end else if (tick) begin
      pcnt <= pcnt - 1'b1;
      if (width_end) fs_q <= 1'b0;
      else           wcnt <= wcnt - 1'b1;
    end
  end

  assign fs_out = fs_q;

endmodule

module frame_sync_gen_chk #(
  parameter int WIDTH_W  = 8,
  parameter int PERIOD_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                gen_en,
  input logic                per_mode,
  input logic                tick,
  input logic                fs_out,
  input logic                run,
  input logic [WIDTH_W-1:0]  wcnt,
  input logic [PERIOD_W-1:0] pcnt
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_low_chk: assert (!fs_out);
  end

  // R2
  property idle_low_p;
    @(posedge clk) disable iff (!rst_n) !(gen_en && per_mode) |=> !fs_out;
  endproperty
  idle_low_chk: assert property (idle_low_p);

  // R3
  property first_start_p;
    @(posedge clk) disable iff (!rst_n) (gen_en && per_mode && tick && !run) |=> fs_out;
  endproperty
  first_start_chk: assert property (first_start_p);

  // R4
  property width_end_p;
    @(posedge clk) disable iff (!rst_n)
      (gen_en && per_mode && tick && run && pcnt != '0 && wcnt == '0) |=> !fs_out;
  endproperty
  width_end_chk: assert property (width_end_p);

  // R5
  property restart_p;
    @(posedge clk) disable iff (!rst_n)
      (gen_en && per_mode && tick && run && pcnt == '0) |=> fs_out;
  endproperty
  restart_chk: assert property (restart_p);

  // R8
  property tick_only_p;
    @(posedge clk) disable iff (!rst_n)
      (gen_en && per_mode && !tick) |=> $stable(fs_out);
  endproperty
  tick_only_chk: assert property (tick_only_p);

endmodule

bind frame_sync_gen frame_sync_gen_chk #(.WIDTH_W(WIDTH_W), .PERIOD_W(PERIOD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .per_mode(per_mode), .tick(tick),
  .fs_out(fs_out), .run(run), .wcnt(wcnt), .pcnt(pcnt)
);

// File: tb/frame_sync_gen_tb_top.sv
`timescale 1ns/1ps
module frame_sync_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_en = 1'b0;
  logic        per_mode = 1'b0;
  logic [7:0]  width_fld = '0;
  logic [11:0] period_fld = '0;
  logic        tick = 1'b0;
  logic        fs_out;

  int n_chk = 0;
  int n_fail = 0;
  bit m_run = 0;
  int m_pos = 0;
  int m_w = 0;
  int m_p = 0;

  always #2.5 clk = ~clk;

  frame_sync_gen dut_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .per_mode(per_mode),
    .width_fld(width_fld), .period_fld(period_fld), .tick(tick), .fs_out(fs_out)
  );

  function automatic bit exp_fs();
    return m_run && (m_pos <= m_w);
  endfunction

  task automatic check(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: fs_out=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit t, bit en, bit md, int w, int p, string req);
    @(negedge clk);
    tick = t; gen_en = en; per_mode = md;
    width_fld = 8'(w); period_fld = 12'(p);
    @(posedge clk);
    #1;
    if (!(en && md)) begin
      m_run = 0; m_pos = 0;
    end else if (t) begin
      if (!m_run || m_pos == m_p) begin
        m_run = 1; m_pos = 0; m_w = w; m_p = p;
      end else m_pos++;
    end
    check(req, fs_out, exp_fs());
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: timeout actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int w, p;
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1 check("R1", fs_out, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R2: one bit alone does not generate
    repeat (4) step(1, 1, 0, 2, 5, "R2");
    repeat (4) step(1, 0, 1, 2, 5, "R2");
    // R3/R4/R5 basic frame W=2 P=5
    repeat (14) step(1, 1, 1, 2, 5, "R4_R5");
    // R8: no ticks, no change
    repeat (5) step(0, 1, 1, 2, 5, "R8");
    // R7: change fields mid-frame
    repeat (3) step(1, 1, 1, 9, 1, "R7");
    repeat (10) step(1, 1, 1, 0, 3, "R7");
    // R6: W equal to P, W above P, both zero
    step(1, 0, 0, 0, 0, "R2");
    repeat (12) step(1, 1, 1, 4, 4, "R6");
    repeat (12) step(1, 1, 1, 7, 3, "R6");
    repeat (6)  step(1, 1, 1, 0, 0, "R6");
    // R2: disable mid-pulse, then R3 fresh start
    step(1, 1, 0, 3, 6, "R2");
    step(0, 1, 1, 3, 6, "R3");
    step(1, 1, 1, 3, 6, "R3");
    // large fields
    repeat (300) step(1, 1, 1, 200, 255, "R4_R5");

    // random mix
    for (int i = 0; i < 20000; i++) begin
      if (i % 500 == 0) begin
        w = $urandom_range(0, 9);
        p = $urandom_range(0, 12);
      end
      if ($urandom_range(0, 99) < 3) begin
        w = $urandom_range(0, 9);
        p = $urandom_range(0, 12);
      end
      step($urandom_range(0, 99) < 60,
           $urandom_range(0, 99) < 98,
           $urandom_range(0, 99) < 98,
           w, p, "R4_R5_R6_R7_R8");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule